// File: doc/BRIEF.md
# Bitmapped Unary Accumulator Sequencer

This block carries out a single unary-operation instruction against a 16-bit accumulator value and its one-bit link extension. The low six bits of the instruction are a bitmap of micro-operations. The sequencer applies the selected ones one per clock, always in the same order, so that combinations build useful composite results. For example, inverting and then incrementing negates the accumulator, and clearing the link and then toggling it sets the link. Each form has a fixed cycle budget. Two forms are conditional: they run only when the link flag or the overflow flag, as sampled at the start, is set.

A controller places the instruction word and the current accumulator, link and overflow values on the inputs and pulses `start` for one cycle while `busy` is low. The block takes its operands in that cycle. After the form's budget it pulses `done` for one cycle. In that same cycle it updates `ac_out` and `l_out` and reports the budget on `cycles_used`. The handshake is a plain strobe, not a stream. While `busy` is high, `start` is dropped and is not queued, so the controller must hold off until `busy` falls. A new `start` is accepted in the cycle that `done` is high.

Top module: `uop_sequencer`

## Requirements
- R1: Bitmap bits [5:0] select, from bit 5 down to bit 0: clear AC, clear link, invert AC, increment AC, decrement AC, toggle link. Only the selected operations take effect.
- R2: Selected operations apply in descending bit order (bit 5 first). Bitmap 001100 turns AC into its two's complement, and bitmap 010001 leaves the link at 1.
- R3: An increment from FFFF (giving 0000) and a decrement from 0000 (giving FFFF) each toggle the link.
- R4: When bits [15:6] equal 0000111000 (unconditional form), `done` arrives 8 cycles after the start cycle and `cycles_used` reads 8, whatever the bitmap.
- R5: When bits [15:6] equal 0000111010 (link-gated form) and `l_in` is 1, the operations run and take 9 cycles. When `l_in` is 0, `done` comes after 3 cycles, `ac_out` and `l_out` keep their values, and `cycles_used` reads 3.
- R6: When bits [15:6] equal 0000111100 (overflow-gated form), behaviour is as in R5 but gated on `v_in`.
- R7: `n_flag` equals bit 15 of `ac_out`, and `z_flag` is 1 exactly when `ac_out` is zero.
- R8: Any other value of bits [15:6] yields `done` 1 cycle after the start cycle, with `cycles_used` 1 and `ac_out`/`l_out` unchanged.
- R9: A `start` pulse while `busy` is high is ignored. The running operation finishes with its own budget and result.
- R10: After reset, `ac_out` is 0, `l_out` is 0, `z_flag` is 1, and `busy`, `done` and `cycles_used` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request, taken only while busy is low |
| instr | input | 16 | Instruction word: form in [15:6], bitmap in [5:0] |
| ac_in | input | 16 | Accumulator operand |
| l_in | input | 1 | Link operand and link-gate condition |
| v_in | input | 1 | Overflow-gate condition |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| ac_out | output | 16 | Accumulator result, updated with done |
| l_out | output | 1 | Link result, updated with done |
| n_flag | output | 1 | Sign of ac_out |
| z_flag | output | 1 | ac_out is zero |
| cycles_used | output | 4 | Budget of the last completed instruction |

## Verification
The bench targets the composite bitmaps where order decides the result. A design that swapped the invert and increment steps would return the one's complement minus one instead of the negation. A design that toggled before clearing the link would leave it at 0. It drives increments at FFFF and decrements at 0000, where a missing link toggle shows up at once. It runs both gated forms with their flag clear and checks that the 3-cycle skip leaves the previous result in place, which catches a design that writes the untouched operand through. It also fires a second `start` in the middle of a run with a conflicting instruction; a design that restarted or re-sampled its operands would then report the wrong result or the wrong cycle count.

// File: rtl/uop_seq_pkg.sv
package uop_seq_pkg;
  typedef enum logic [1:0] {
    FORM_NONE,
    FORM_ALWAYS,
    FORM_IF_LINK,
    FORM_IF_OVF
  } form_e;

  localparam int OPC_W = 10;
  localparam int MAP_W = 6;
  localparam logic [OPC_W-1:0] OPC_ALWAYS  = 10'b0000111000;
  localparam logic [OPC_W-1:0] OPC_IF_LINK = 10'b0000111010;
  localparam logic [OPC_W-1:0] OPC_IF_OVF  = 10'b0000111100;
endpackage

// File: rtl/uop_form_decode.sv
module uop_form_decode
  import uop_seq_pkg::*;
#(
  parameter int CW       = 4,
  parameter int CYC_RUN  = 8,
  parameter int CYC_COND = 9,
  parameter int CYC_SKIP = 3,
  parameter int CYC_IGN  = 1
) (
  input  logic [OPC_W-1:0] opc,
  input  logic             link,
  input  logic             ovf,
  output form_e            form,
  output logic             run_ops,
  output logic [CW-1:0]    budget
);
  always_comb begin
    unique case (opc)
      OPC_ALWAYS:  form = FORM_ALWAYS;
      OPC_IF_LINK: form = FORM_IF_LINK;
      OPC_IF_OVF:  form = FORM_IF_OVF;
      default:     form = FORM_NONE;
    endcase
  end

  always_comb begin
    unique case (form)
      FORM_ALWAYS: begin
        run_ops = 1'b1;
        budget  = CW'(CYC_RUN);
      end
      FORM_IF_LINK: begin
        run_ops = link;
        budget  = link ? CW'(CYC_COND) : CW'(CYC_SKIP);
      end
      FORM_IF_OVF: begin
        run_ops = ovf;
        budget  = ovf ? CW'(CYC_COND) : CW'(CYC_SKIP);
      end
      default: begin
        run_ops = 1'b0;
        budget  = CW'(CYC_IGN);
      end
    endcase
  end
endmodule

// File: rtl/uop_step.sv
module uop_step #(
  parameter int W = 16
) (
  input  logic [2:0]   slot,
  input  logic         en,
  input  logic [W-1:0] ac,
  input  logic         link,
  output logic [W-1:0] ac_nx,
  output logic         link_nx
);
  always_comb begin
    ac_nx   = ac;
    link_nx = link;
    if (en) begin
      unique case (slot)
        3'd0: ac_nx = '0;
        3'd1: link_nx = 1'b0;
        3'd2: ac_nx = ~ac;
        3'd3: begin
          ac_nx = ac + W'(1);
          if (&ac) link_nx = ~link;
        end
        3'd4: begin
          ac_nx = ac - W'(1);
          if (ac == '0) link_nx = ~link;
        end
        3'd5: link_nx = ~link;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uop_sequencer.sv
module uop_sequencer
  import uop_seq_pkg::*;
#(
  parameter int W        = 16,
  parameter int CYC_RUN  = 8,
  parameter int CYC_COND = 9,
  parameter int CYC_SKIP = 3,
  parameter int CYC_IGN  = 1,
  localparam int CW      = $clog2(CYC_COND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   instr,
  input  logic [W-1:0]  ac_in,
  input  logic          l_in,
  input  logic          v_in,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  ac_out,
  output logic          l_out,
  output logic          n_flag,
  output logic          z_flag,
  output logic [CW-1:0] cycles_used
);
  form_e            form;
  logic             run_ops;
  logic [CW-1:0]    budget;
  logic [CW-1:0]    remain;
  logic [CW-1:0]    budget_q;
  logic             commit_q;
  logic [MAP_W-1:0] map_q;
  logic [2:0]       slot_q;
  logic [W-1:0]     wac, wac_nx;
  logic             wl, wl_nx;
  logic             slot_live;

  uop_form_decode #(
    .CW(CW), .CYC_RUN(CYC_RUN), .CYC_COND(CYC_COND),
    .CYC_SKIP(CYC_SKIP), .CYC_IGN(CYC_IGN)
  ) u_dec (
    .opc(instr[15:6]), .link(l_in), .ovf(v_in),
    .form(form), .run_ops(run_ops), .budget(budget)
  );

  assign slot_live = (slot_q < 3'(MAP_W));

  uop_step #(.W(W)) u_step (
    .slot(slot_q), .en(map_q[MAP_W-1] & slot_live),
    .ac(wac), .link(wl), .ac_nx(wac_nx), .link_nx(wl_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      done        <= 1'b0;
      ac_out      <= '0;
      l_out       <= 1'b0;
      cycles_used <= '0;
      remain      <= '0;
      budget_q    <= '0;
      commit_q    <= 1'b0;
      map_q       <= '0;
      slot_q      <= '0;
      wac         <= '0;
      wl          <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        if (budget == CW'(1)) begin
          done        <= 1'b1;
          cycles_used <= budget;
        end else begin
          busy     <= 1'b1;
          remain   <= budget - CW'(1);
          budget_q <= budget;
          commit_q <= run_ops;
          map_q    <= run_ops ? instr[MAP_W-1:0] : '0;
          slot_q   <= '0;
          wac      <= ac_in;
          wl       <= l_in;
        end
      end else if (busy) begin
        if (slot_live) begin
          wac    <= wac_nx;
          wl     <= wl_nx;
          map_q  <= {map_q[MAP_W-2:0], 1'b0};
          slot_q <= slot_q + 3'd1;
        end
        if (remain == CW'(1)) begin
          busy        <= 1'b0;
          done        <= 1'b1;
          cycles_used <= budget_q;
          if (commit_q) begin
            ac_out <= wac;
            l_out  <= wl;
          end
        end else begin
          remain <= remain - CW'(1);
        end
      end
    end
  end

  assign n_flag = ac_out[W-1];
  assign z_flag = (ac_out == '0);
endmodule

// File: rtl/uop_sequencer_chk.sv
module uop_sequencer_chk #(
  parameter int W  = 16,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [W-1:0]  ac_out,
  input logic          l_out,
  input logic [CW-1:0] cycles_used
);
  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy || done));

  // R4
  budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles_used == CW'(1) || cycles_used == CW'(3) ||
              cycles_used == CW'(8) || cycles_used == CW'(9)));

  // R5
  result_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(ac_out) || !$stable(l_out)) |-> done);
endmodule

bind uop_sequencer uop_sequencer_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .ac_out(ac_out), .l_out(l_out), .cycles_used(cycles_used)
);

// File: tb/tb_uop_sequencer.sv
module tb_uop_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] ac_in = '0;
  logic        l_in = 1'b0;
  logic        v_in = 1'b0;
  logic        busy, done, l_out, n_flag, z_flag;
  logic [15:0] ac_out;
  logic [3:0]  cycles_used;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_ac = '0;
  logic        exp_l = 1'b0;

  always #5 clk = ~clk;

  uop_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .ac_in(ac_in), .l_in(l_in), .v_in(v_in), .busy(busy), .done(done),
    .ac_out(ac_out), .l_out(l_out), .n_flag(n_flag), .z_flag(z_flag),
    .cycles_used(cycles_used)
  );

  function automatic logic [16:0] model(input logic [15:0] a, input logic l,
                                        input logic [5:0] m);
    if (m[5]) a = '0;
    if (m[4]) l = 1'b0;
    if (m[3]) a = ~a;
    if (m[2]) begin if (a == 16'hFFFF) l = ~l; a = a + 16'd1; end
    if (m[1]) begin if (a == 16'h0000) l = ~l; a = a - 16'd1; end
    if (m[0]) l = ~l;
    return {l, a};
  endfunction

  function automatic int budget_of(input logic [9:0] opc, input logic l,
                                   input logic v, output logic runs);
    runs = 1'b0;
    if (opc == 10'b0000111000) begin runs = 1'b1; return 8; end
    if (opc == 10'b0000111010) begin runs = l; return l ? 9 : 3; end
    if (opc == 10'b0000111100) begin runs = v; return v ? 9 : 3; end
    return 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] ins, input logic [15:0] a,
                     input logic l, input logic v, input bit inject,
                     input string req);
    int n;
    int c;
    logic runs;
    logic [16:0] r;
    c = budget_of(ins[15:6], l, v, runs);
    if (runs) begin
      r = model(a, l, ins[5:0]);
      exp_ac = r[15:0];
      exp_l = r[16];
    end
    @(negedge clk);
    instr = ins; ac_in = a; l_in = l; v_in = v; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 40) begin
      if (inject && n == 2) begin
        // R9: conflicting request during busy
        start = 1'b1; instr = {10'b0000111000, 6'b100001};
        ac_in = ~a; l_in = ~l; v_in = ~v;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check({req, " latency"}, n, c);
    check({req, " cycles_used"}, cycles_used, c);
    check({req, " ac_out"}, ac_out, exp_ac);
    check({req, " l_out"}, l_out, exp_l);
    // R7
    check("R7 n_flag", n_flag, exp_ac[15]);
    check("R7 z_flag", z_flag, exp_ac == 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] opc;
    int f;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R10
    check("R10 ac_out", ac_out, 0);
    check("R10 l_out", l_out, 0);
    check("R10 z_flag", z_flag, 1);
    check("R10 busy", busy, 0);
    check("R10 done", done, 0);
    check("R10 cycles_used", cycles_used, 0);
    rst_n = 1'b1;

    run({10'b0000111000, 6'b001100}, 16'h0005, 1'b0, 1'b0, 0, "R2 negate");
    run({10'b0000111000, 6'b010001}, 16'h1234, 1'b0, 1'b0, 0, "R2 set link");
    run({10'b0000111000, 6'b000100}, 16'hFFFF, 1'b0, 1'b0, 0, "R3 inc wrap");
    run({10'b0000111000, 6'b000010}, 16'h0000, 1'b1, 1'b0, 0, "R3 dec wrap");
    run({10'b0000111000, 6'b000000}, 16'h8001, 1'b1, 1'b0, 0, "R4 empty map");
    run({10'b0000111000, 6'b100000}, 16'h7777, 1'b0, 1'b0, 0, "R1 clear ac");
    run({10'b0000111010, 6'b001000}, 16'h00F0, 1'b1, 1'b0, 0, "R5 link taken");
    run({10'b0000111010, 6'b111111}, 16'hABCD, 1'b0, 1'b1, 0, "R5 link skip");
    run({10'b0000111100, 6'b000101}, 16'h4000, 1'b0, 1'b1, 0, "R6 ovf taken");
    run({10'b0000111100, 6'b100000}, 16'h1111, 1'b1, 1'b0, 0, "R6 ovf skip");
    run({10'b0000111110, 6'b100000}, 16'h2222, 1'b1, 1'b1, 0, "R8 ignored");
    run({10'b0000111000, 6'b000100}, 16'h0041, 1'b0, 1'b0, 1, "R9 busy start");

    for (int i = 0; i < 80; i++) begin
      f = int'($urandom_range(0, 3));
      case (f)
        0: opc = 10'b0000111000;
        1: opc = 10'b0000111010;
        2: opc = 10'b0000111100;
        default: begin
          opc = 10'($urandom);
          if (opc == 10'b0000111000 || opc == 10'b0000111010 ||
              opc == 10'b0000111100) opc = 10'b1111111111;
        end
      endcase
      run({opc, 6'($urandom)}, 16'($urandom), 1'($urandom), 1'($urandom),
          ($urandom_range(0, 4) == 0), "R1 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule